// File: doc/BRIEF.md
# Thresholded Event Counter Slice

This block is one performance-monitoring counter. Software programs a 32-bit control word that selects an event source and a set of its sub-event lines, sets a threshold, and picks how counting works. Every clock, the block adds the per-cycle increments of the chosen sub-event lines. It then qualifies that sum against the threshold, optionally passes the result through a rising-edge detector, and adds the result to a 48-bit accumulator.

When the accumulator carries out of its top bit, it wraps and keeps counting. If overflow reporting is enabled, the block also latches a local status flag and emits a one-cycle overflow message toward a global controller. Software can preload the accumulator with 2^48 − N so that the overflow fires after N events. It can read the accumulator at any time, and counting does not pause while it does.

Register access is a single-cycle write strobe with a 2-bit address and a combinational read of the addressed word. The event inputs are a flat bank of per-line increment fields, one bank per supported event source.

Top module: `pmon_ctr_slice`

## Requirements
- R1: After reset, all four registers read 0 and `ovf_msg` is 0.
- R2: The control word (address 0) has these fields: event code in bits 7:0, sub-event mask in 15:8, a clear strobe in 17, edge mode in 18, overflow reporting in 20, enable in 22 and threshold in 31:24. The word reads back as written, except that bits 16, 17, 19, 21 and 23 always read 0.
- R3: Event code 0x01+i selects event source i, for i from 0 to 3. Any other code gives a zero increment, so the counter does not move.
- R4: The raw increment is the sum of sub-event lines j whose mask bit j is 1. Line j of source i is `evt_lines[(i*8+j)*2 +: 2]`. With threshold 0 and edge mode off, the counter adds the raw increment each enabled cycle.
- R5: With a nonzero threshold and edge mode off, the counter adds 1 in each enabled cycle where the raw increment is at least the threshold, and adds 0 otherwise.
- R6: In edge mode, the qualified condition is "raw ≥ threshold" for a nonzero threshold, or "raw ≠ 0" for a zero threshold. The counter adds 1 only when that condition is true in this cycle and was false in the previous cycle. The previous cycle counts as false if the counter was disabled in it.
- R7: While the enable bit is 0, the counter does not change except through register writes.
- R8: A control write with bit 17 set clears the counter to 0 at that clock edge.
- R9: Address 1 reads and writes counter bits 31:0. Address 2 reads and writes bits 47:32 in its low 16 bits, with the upper bits reading 0. Writing one half leaves the other half unchanged. Reads never disturb counting.
- R10: The counter adds modulo 2^48 and keeps counting after it wraps.
- R11: If a count wraps past 2^48 − 1 while overflow reporting is on, status bit 0 (address 3) is 1 from the next cycle and `ovf_msg` is high for exactly that one cycle. This happens on every wrap, even when the status bit is already 1. With overflow reporting off, neither happens.
- R12: Writing 1 to status bit 0 clears it. If an overflow occurs in the same cycle, the overflow wins and the bit stays 1.
- R13: In a cycle with a clear strobe or a counter write, the write decides the new counter value, that cycle's events are dropped, and no overflow is reported. Control writes take effect for counting from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_lines | input | 64 | Per-cycle increment fields, 2 bits per line, 8 lines per source, 4 sources |
| ovf_msg | output | 1 | One-cycle overflow message to the global controller |

## Verification
The accumulator is the state most likely to go wrong. A wrong value there shows up on the very next cycle through the count-low read, because the bench keeps that address selected while counting. The edge-detector memory and the threshold path are internal, so a fault in either appears only as a count that is off by one or more after a few cycles. The bench therefore drives short patterns of known shape and compares the count on every clock. A missed or duplicated overflow shows up on `ovf_msg` exactly one cycle after the wrapping edge, and on the status read in the same cycle.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  localparam int REG_DW = 32;

  // control word bit positions (software-visible layout)
  localparam int CB_EVT_LO  = 0;
  localparam int CB_MASK_LO = 8;
  localparam int CB_CLR     = 17;
  localparam int CB_EDGE    = 18;
  localparam int CB_OVEN    = 20;
  localparam int CB_EN      = 22;
  localparam int CB_THR_LO  = 24;

  typedef enum logic [1:0] {
    RA_CTL    = 2'd0,
    RA_CNT_LO = 2'd1,
    RA_CNT_HI = 2'd2,
    RA_STAT   = 2'd3
  } pmon_ra_e;

  typedef struct packed {
    logic [7:0] thresh;
    logic       en;
    logic       ov_en;
    logic       edge_mode;
    logic [7:0] umask;
    logic [7:0] ev_sel;
  } pmon_ctl_t;

  function automatic pmon_ctl_t ctl_from_word(input logic [REG_DW-1:0] w);
    pmon_ctl_t c;
    c.thresh    = w[CB_THR_LO +: 8];
    c.en        = w[CB_EN];
    c.ov_en     = w[CB_OVEN];
    c.edge_mode = w[CB_EDGE];
    c.umask     = w[CB_MASK_LO +: 8];
    c.ev_sel    = w[CB_EVT_LO +: 8];
    return c;
  endfunction

  function automatic logic [REG_DW-1:0] ctl_to_word(input pmon_ctl_t c);
    logic [REG_DW-1:0] w;
    w = '0;
    w[CB_THR_LO +: 8]  = c.thresh;
    w[CB_EN]           = c.en;
    w[CB_OVEN]         = c.ov_en;
    w[CB_EDGE]         = c.edge_mode;
    w[CB_MASK_LO +: 8] = c.umask;
    w[CB_EVT_LO +: 8]  = c.ev_sel;
    return w;
  endfunction

endpackage

// File: rtl/pmon_evt_sel.sv
module pmon_evt_sel #(
  parameter int NUM_EVT  = 4,
  parameter int NUM_SUB  = 8,
  parameter int LINE_W   = 2,
  parameter int EVT_BASE = 1,
  parameter int SUM_W    = 5,
  localparam int LINES_W = NUM_EVT * NUM_SUB * LINE_W
) (
  input  logic [7:0]         ev_sel,
  input  logic [7:0]         umask,
  input  logic [LINES_W-1:0] lines,
  output logic [SUM_W-1:0]   raw_inc
);

  logic [NUM_EVT*SUM_W-1:0] gated_sums;

  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
    logic [SUM_W-1:0] sum_v;
    logic             hit;

    always_comb begin
      sum_v = '0;
      for (int j = 0; j < NUM_SUB; j++) begin
        if (umask[j]) begin
          sum_v = sum_v + SUM_W'(lines[(gi*NUM_SUB + j)*LINE_W +: LINE_W]);
        end
      end
    end

    assign hit = (ev_sel == 8'(EVT_BASE + gi));
    assign gated_sums[gi*SUM_W +: SUM_W] = hit ? sum_v : '0;
  end

  // codes are distinct, so at most one slice is nonzero
  always_comb begin
    raw_inc = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      raw_inc = raw_inc | gated_sums[i*SUM_W +: SUM_W];
    end
  end

endmodule

// File: rtl/pmon_qualify.sv
module pmon_qualify #(
  parameter int SUM_W = 5,
  parameter int THR_W = 8,
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             edge_mode,
  input  logic [THR_W-1:0] thresh,
  input  logic [SUM_W-1:0] raw_inc,
  output logic [SUM_W-1:0] delta
);

  logic             prev_q;
  logic             prev_nxt;
  logic             thr_zero;
  logic             qual;
  logic [CMP_W-1:0] raw_x;
  logic [CMP_W-1:0] thr_x;
  logic [SUM_W-1:0] level_delta;
  logic [SUM_W-1:0] edge_delta;

  assign raw_x    = CMP_W'(raw_inc);
  assign thr_x    = CMP_W'(thresh);
  assign thr_zero = (thresh == '0);

  always_comb begin
    if (thr_zero) begin
      qual        = (raw_inc != '0);
      level_delta = raw_inc;
    end else begin
      qual        = (raw_x >= thr_x);
      level_delta = SUM_W'(qual);
    end
    edge_delta = SUM_W'(qual & ~prev_q);
    if (!en) begin
      delta = '0;
    end else if (edge_mode) begin
      delta = edge_delta;
    end else begin
      delta = level_delta;
    end
    prev_nxt = en & qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_nxt;
    end
  end

endmodule

// File: rtl/pmon_accum.sv
module pmon_accum #(
  parameter int CNT_W   = 48,
  parameter int DELTA_W = 5,
  localparam int LO_W   = 32,
  localparam int HI_W   = CNT_W - LO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [31:0]        ld_data,
  input  logic [DELTA_W-1:0] delta,
  input  logic               ov_en,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_hit,
  output logic               msg_q
);

  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_ce;

  assign sum_w  = {1'b0, cnt_q} + (CNT_W+1)'(delta);
  assign cnt_ce = clr | ld_lo | ld_hi | (|delta);

  always_comb begin
    cnt_nxt = cnt_q;
    ovf_hit = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
    end else if (ld_lo) begin
      cnt_nxt = {cnt_q[CNT_W-1:LO_W], ld_data};
    end else if (ld_hi) begin
      cnt_nxt = {ld_data[HI_W-1:0], cnt_q[LO_W-1:0]};
    end else begin
      cnt_nxt = sum_w[CNT_W-1:0];
      ovf_hit = sum_w[CNT_W] & ov_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= 1'b0;
    end else begin
      msg_q <= ovf_hit;
    end
  end

endmodule

// File: rtl/pmon_ctr_slice.sv
module pmon_ctr_slice
  import pmon_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int NUM_SUB  = 8,
  parameter int LINE_W   = 2,
  parameter int CNT_W    = 48,
  parameter int EVT_BASE = 1,
  localparam int LINES_W = NUM_EVT * NUM_SUB * LINE_W,
  localparam int SUM_W   = $clog2(NUM_SUB * ((1 << LINE_W) - 1) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [LINES_W-1:0] evt_lines,
  output logic               ovf_msg
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // register decode
  logic wr_ctl, wr_lo, wr_hi, wr_stat;
  logic clr_req;
  logic unused_rsv_bits;

  assign wr_ctl  = reg_wr_en & (reg_addr == RA_CTL);
  assign wr_lo   = reg_wr_en & (reg_addr == RA_CNT_LO);
  assign wr_hi   = reg_wr_en & (reg_addr == RA_CNT_HI);
  assign wr_stat = reg_wr_en & (reg_addr == RA_STAT);
  assign clr_req = wr_ctl & reg_wdata[CB_CLR];
  assign unused_rsv_bits = ^{reg_wdata[16], reg_wdata[19], reg_wdata[21], reg_wdata[23]};

  // control register
  pmon_ctl_t ctl_q, ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_ctl) begin
      ctl_nxt = ctl_from_word(reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= ctl_nxt;
    end
  end

  // datapath
  logic [SUM_W-1:0] raw_inc;
  logic [SUM_W-1:0] delta;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_hit;

  pmon_evt_sel #(
    .NUM_EVT (NUM_EVT),
    .NUM_SUB (NUM_SUB),
    .LINE_W  (LINE_W),
    .EVT_BASE(EVT_BASE),
    .SUM_W   (SUM_W)
  ) u_sel (
    .ev_sel (ctl_q.ev_sel),
    .umask  (ctl_q.umask),
    .lines  (evt_lines),
    .raw_inc(raw_inc)
  );

  pmon_qualify #(
    .SUM_W(SUM_W),
    .THR_W(8)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (ctl_q.en),
    .edge_mode(ctl_q.edge_mode),
    .thresh   (ctl_q.thresh),
    .raw_inc  (raw_inc),
    .delta    (delta)
  );

  pmon_accum #(
    .CNT_W  (CNT_W),
    .DELTA_W(SUM_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (clr_req),
    .ld_lo  (wr_lo),
    .ld_hi  (wr_hi),
    .ld_data(reg_wdata),
    .delta  (delta),
    .ov_en  (ctl_q.ov_en),
    .cnt_q  (cnt_q),
    .ovf_hit(ovf_hit),
    .msg_q  (ovf_msg)
  );

  // local status: set by overflow, cleared by write-one
  logic stat_q, stat_nxt, stat_ce;

  always_comb begin
    stat_nxt = stat_q;
    if (ovf_hit) begin
      stat_nxt = 1'b1;
    end else if (wr_stat && reg_wdata[0]) begin
      stat_nxt = 1'b0;
    end
    stat_ce = ovf_hit | wr_stat;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= 1'b0;
    end else if (stat_ce) begin
      stat_q <= stat_nxt;
    end
  end

  // read mux
  always_comb begin
    unique case (pmon_ra_e'(reg_addr))
      RA_CTL:    reg_rdata = ctl_to_word(ctl_q);
      RA_CNT_LO: reg_rdata = cnt_q[31:0];
      RA_CNT_HI: reg_rdata = 32'(cnt_q[CNT_W-1:32]);
      RA_STAT:   reg_rdata = {31'b0, stat_q};
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pmon_ctr_slice_chk.sv
module pmon_ctr_slice_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             stat_q,
  input logic             ctl_en,
  input logic             ctl_ov_en,
  input logic             ctl_edge,
  input logic             ovf_msg
);

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_msg |=> !ovf_msg); // R11

  AST_MSG_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_msg |-> stat_q); // R11

  AST_NO_MSG_UNREPORTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl_ov_en |=> !ovf_msg); // R11

  AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == 2'd0 && reg_wdata[17]) |=> (cnt_q == '0)); // R8

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_en && !reg_wr_en) |=> $stable(cnt_q)); // R7

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_en && ctl_edge && !reg_wr_en) |=> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R6

  AST_CTL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == 2'd0) |-> ((reg_rdata & 32'h00AB_0000) == 32'h0)); // R2

  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == 2'd2) |-> (reg_rdata[31:16] == 16'h0)); // R9

endmodule

bind pmon_ctr_slice pmon_ctr_slice_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cnt_q     (cnt_q),
  .stat_q    (stat_q),
  .ctl_en    (ctl_q.en),
  .ctl_ov_en (ctl_q.ov_en),
  .ctl_edge  (ctl_q.edge_mode),
  .ovf_msg   (ovf_msg)
);

// File: tb/pmon_ctr_slice_tb.sv
module pmon_ctr_slice_tb;

  localparam longint unsigned CMASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] evt_lines;
  logic        ovf_msg;

  always #4 clk = ~clk;

  pmon_ctr_slice u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .evt_lines(evt_lines),
    .ovf_msg  (ovf_msg)
  );

  // reference state
  longint unsigned m_cnt;
  logic [31:0]     m_ctl;
  bit              m_stat, m_msg, m_prev;
  int              errors = 0;
  int              checks = 0;
  string           cur_tag = "R1";
  bit              done = 0;

  function automatic logic [31:0] ctlw(input int ev, input int um, input int th,
                                       input bit edg, input bit oven, input bit en,
                                       input bit clr);
    return {th[7:0], 1'b0, en, 1'b0, oven, 1'b0, edg, clr, 1'b0, um[7:0], ev[7:0]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctl;
      2'd1:    return m_cnt[31:0];
      2'd2:    return {16'h0, m_cnt[47:32]};
      default: return {31'h0, m_stat};
    endcase
  endfunction

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance the reference from requirements, then compare
  task automatic tick();
    int              ev, raw, th;
    bit              en, edg, oven, qual, ovf;
    longint unsigned sum, n_cnt;
    bit              n_stat, n_msg, n_prev;
    logic [31:0]     n_ctl;
    ev   = int'(m_ctl[7:0]) - 1;                    // R3
    th   = int'(m_ctl[31:24]);
    en   = m_ctl[22];
    edg  = m_ctl[18];
    oven = m_ctl[20];
    raw  = 0;
    if (ev >= 0 && ev < 4) begin
      for (int j = 0; j < 8; j++)
        if (m_ctl[8+j]) raw += int'(evt_lines[(ev*8+j)*2 +: 2]);  // R4
    end
    qual = (th == 0) ? (raw != 0) : (raw >= th);    // R5
    if (!en) sum = 0;                               // R7
    else if (edg) sum = (qual && !m_prev) ? 1 : 0;  // R6
    else sum = (th == 0) ? longint'(raw) : (qual ? 1 : 0);
    n_cnt = m_cnt; ovf = 0; n_ctl = m_ctl;
    if (reg_wr_en && reg_addr == 2'd0) n_ctl = reg_wdata & 32'hFF54_FFFF;
    if (reg_wr_en && reg_addr == 2'd0 && reg_wdata[17]) n_cnt = 0;             // R8, R13
    else if (reg_wr_en && reg_addr == 2'd1) n_cnt = (m_cnt & 64'hFFFF_0000_0000) | reg_wdata;
    else if (reg_wr_en && reg_addr == 2'd2) n_cnt = (m_cnt & 64'hFFFF_FFFF) | (longint'(reg_wdata[15:0]) << 32);
    else begin
      n_cnt = m_cnt + sum;
      ovf   = (n_cnt > CMASK);                      // R10
      n_cnt = n_cnt & CMASK;
    end
    n_msg  = ovf && oven;                           // R11
    n_stat = m_stat;
    if (ovf && oven) n_stat = 1;
    else if (reg_wr_en && reg_addr == 2'd3 && reg_wdata[0]) n_stat = 0;        // R12
    n_prev = en && qual;
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_ctl = n_ctl; m_stat = n_stat; m_msg = n_msg; m_prev = n_prev;
    check(cur_tag, reg_rdata, exp_read(reg_addr));
    check("R11", ovf_msg, m_msg);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic run(input int n, input logic [1:0] a);
    reg_addr = a;
    repeat (n) begin
      evt_lines = {$urandom, $urandom};
      tick();
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pat [12] = '{0, 1, 1, 0, 2, 0, 3, 3, 0, 1, 0, 2};
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = '0; evt_lines = '0;
    m_cnt = 0; m_ctl = 0; m_stat = 0; m_msg = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    cur_tag = "R1";
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1 check("R1", reg_rdata, 32'h0);
    end
    check("R1", ovf_msg, 0);

    // R2 control readback with reserved bits masked
    cur_tag = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    reg_addr = 2'd0; tick();
    check("R2", reg_rdata, 32'hFF54_FFFF);
    wr(2'd0, ctlw(0, 0, 0, 0, 0, 0, 1));

    // R4 raw sum of masked lines
    cur_tag = "R4";
    wr(2'd0, ctlw(8'h01, 8'hA5, 0, 0, 0, 1, 0));
    run(20, 2'd1);

    // R3 event selection and unsupported codes
    cur_tag = "R3";
    wr(2'd0, ctlw(8'h03, 8'hFF, 0, 0, 0, 1, 0));
    run(10, 2'd1);
    wr(2'd0, ctlw(8'h00, 8'hFF, 0, 0, 0, 1, 0));
    run(8, 2'd1);
    wr(2'd0, ctlw(8'h09, 8'hFF, 0, 0, 0, 1, 0));
    run(8, 2'd1);

    // R5 threshold qualification
    cur_tag = "R5";
    wr(2'd0, ctlw(8'h02, 8'h0F, 3, 0, 0, 1, 0));
    run(20, 2'd1);
    wr(2'd0, ctlw(8'h02, 8'hFF, 8'hFF, 0, 0, 1, 0));
    run(8, 2'd1);

    // R6 edge mode with a shaped pattern on line 0 of source 0
    cur_tag = "R6";
    wr(2'd0, ctlw(8'h01, 8'h01, 1, 1, 0, 1, 0));
    reg_addr = 2'd1;
    foreach (pat[k]) begin
      evt_lines = 64'(pat[k]);
      tick();
    end
    wr(2'd0, ctlw(8'h01, 8'h01, 0, 1, 0, 1, 0));
    foreach (pat[k]) begin
      evt_lines = 64'(pat[k]);
      reg_addr = 2'd1;
      tick();
    end
    wr(2'd0, ctlw(8'h04, 8'hFF, 6, 1, 0, 1, 0));
    run(20, 2'd1);

    // R7 disabled
    cur_tag = "R7";
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 0, 0, 0));
    run(10, 2'd1);

    // R8 clear strobe while counting
    cur_tag = "R8";
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 0, 1, 0));
    run(5, 2'd1);
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 0, 1, 1));
    reg_addr = 2'd1; evt_lines = '0; tick();
    check("R8", reg_rdata, 32'h0);

    // R9 preload halves and live reads
    cur_tag = "R9";
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_ABCD);
    run(10, 2'd2);
    run(10, 2'd1);

    // R10 / R11 wrap with reporting
    cur_tag = "R10";
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 1, 1, 0));
    wr(2'd1, 32'hFFFF_FFE2);
    wr(2'd2, 32'h0000_FFFF);
    run(6, 2'd2);
    run(10, 2'd1);
    cur_tag = "R11";
    run(4, 2'd3);

    // R12 clear status, then overflow again while set
    cur_tag = "R12";
    wr(2'd3, 32'h1);
    run(2, 2'd3);
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd2, 32'h0000_FFFF);
    run(10, 2'd3);
    cur_tag = "R11";
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd2, 32'h0000_FFFF);
    run(10, 2'd3);
    // reporting off: wrap without message
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 0, 1, 0));
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd2, 32'h0000_FFFF);
    run(10, 2'd1);

    // R13 writes win over counting
    cur_tag = "R13";
    wr(2'd0, ctlw(8'h01, 8'hFF, 0, 0, 1, 1, 0));
    evt_lines = '1;
    wr(2'd1, 32'h0000_0100);
    reg_addr = 2'd1; tick();
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_FFFF);
    run(3, 2'd3);

    // mixed random traffic, every clock compared
    cur_tag = "R10";
    for (int r = 0; r < 40; r++) begin
      int th_pick;
      th_pick = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 12));
      wr(2'd0, ctlw($urandom_range(0, 5), $urandom, th_pick, $urandom_range(0, 1),
                    $urandom_range(0, 1), ($urandom_range(0, 4) != 0), 0));
      if ($urandom_range(0, 1) == 1) begin
        wr(2'd1, 32'hFFFF_FFFF - $urandom_range(0, 200));
        wr(2'd2, 32'h0000_FFFF);
      end
      for (int c = 0; c < 100; c++) begin
        evt_lines = {$urandom, $urandom};
        reg_addr  = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 30) == 0) begin
          reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1;
        end
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule